// File: doc/BRIEF.md
# Read Strobe Framer

This block drives the read data strobe pair and its output enable around a burst of read data. Between bursts the strobe pair is released (output enable low), which saves I/O power. When a read is launched, the strobe is first held low for a preamble. It then toggles once per half clock for the length of the burst. A single half-clock low postamble follows, and then the pair is released again. Data lanes are aligned to the strobe edges only, never to the system clock.

The block runs on a clock at twice the system clock rate, so every cycle is one half-clock slot. A one-slot pulse on `rd_start` launches a burst. `burst_chop` is sampled together with that pulse and selects a long burst (8 toggles) or a chopped burst (4 toggles). A start that arrives in the final toggle slot chains the next burst straight on, with no postamble and no preamble. Whenever the strobe is released, `dq_term` tells the data lanes whether to keep on-die termination or float, following the termination request `odt_on`.

States: IDLE (released), PRE (preamble), BURST (toggling), POST (postamble). Transitions: IDLE→PRE on start; PRE→BURST after the last preamble slot; BURST→BURST on a start in the last toggle slot (chain); BURST→POST at the end of the burst without a start; POST→PRE on start; POST→IDLE otherwise.

Top module: `rd_strobe_framer`

## Requirements
- R1: After reset, and whenever no read is in progress, `dqs_oe`, `dqs` and `dqs_n` are all 0.
- R2: A `rd_start` sampled in IDLE makes the next two slots a preamble: `dqs_oe`=1, `dqs`=0, `dqs_n`=1.
- R3: After the preamble the strobe toggles once per slot, starting at `dqs`=1 (1,0,1,0,…), for 8 slots when `burst_chop`=0 and 4 slots when `burst_chop`=1. `burst_chop` is sampled in the same slot as `rd_start`.
- R4: The last toggle slot is followed by exactly one postamble slot (`dqs_oe`=1, `dqs`=0) and then by IDLE.
- R5: Whenever `dqs_oe`=1, `dqs_n` is the complement of `dqs`.
- R6: A `rd_start` sampled in the last toggle slot continues the toggling in the next slot (`dqs`=1) with the newly sampled burst length, with no postamble and no preamble in between.
- R7: A `rd_start` sampled during the preamble, or in any toggle slot other than the last, has no effect on the strobe sequence.
- R8: While `dqs_oe`=0, `dq_term` equals `odt_on` as sampled at the previous clock edge. While `dqs_oe`=1, `dq_term` is 0.
- R9: A `rd_start` sampled in the postamble slot starts a new preamble in the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Half-clock slot clock (twice the system clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | One-slot pulse that launches a read burst |
| burst_chop | input | 1 | 0 = 8 toggles, 1 = 4 toggles; sampled with rd_start |
| odt_on | input | 1 | Termination request for the data lanes |
| dqs | output | 1 | True strobe |
| dqs_n | output | 1 | Complement strobe |
| dqs_oe | output | 1 | Strobe pair output enable |
| dq_term | output | 1 | 1 = keep data lanes terminated, 0 = float or drive |

## Verification
Every output comes straight from registers that are updated at the edge where the inputs are sampled. So the strobe and its enable show the effect of a `rd_start` in the slot right after the sampling edge, and `dq_term` follows `odt_on` with the same one-slot delay. The driver tags each expected value with the number of the slot it belongs to: one more than the slot in which the input was applied. The monitor compares only at the falling edge of that exact slot, so a value that comes early or late is reported as a mismatch.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_BURST = 2'd2,
        ST_POST  = 2'd3
    } rdq_state_e;
endpackage

// File: rtl/rdq_fsm.sv
module rdq_fsm
    import rdq_pkg::*;
#(
    parameter int PRE_SLOTS     = 2,
    parameter int LONG_TOGGLES  = 8,
    parameter int SHORT_TOGGLES = 4,
    parameter int CNT_W         = $clog2(LONG_TOGGLES + PRE_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic             burst_chop,
    output rdq_state_e       state,
    output logic [CNT_W-1:0] slot
);
    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_SLOTS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TOGGLES - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TOGGLES - 1);

    rdq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_q, last_d;
    logic [CNT_W-1:0] req_last;

    assign req_last = burst_chop ? SHORT_LAST : LONG_LAST;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        last_d  = last_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (rd_start) begin
                    state_d = ST_PRE;
                    last_d  = req_last;
                end
            end
            ST_PRE: begin
                if (cnt_q == PRE_LAST) begin
                    state_d = ST_BURST;
                    cnt_d   = '0;
                end
            end
            ST_BURST: begin
                if (cnt_q == last_q) begin
                    cnt_d = '0;
                    if (rd_start) begin
                        last_d = req_last;
                    end else begin
                        state_d = ST_POST;
                    end
                end
            end
            ST_POST: begin
                cnt_d = '0;
                if (rd_start) begin
                    state_d = ST_PRE;
                    last_d  = req_last;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= LONG_LAST;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
        end
    end

    assign state = state_q;
    assign slot  = cnt_q;

    // R2: a start seen while released opens a preamble
    a_r2_start_opens_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_start) |=> (state_q == ST_PRE && cnt_q == '0));

    // R3: the preamble hands over to toggling at its last slot
    a_r3_pre_to_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE && cnt_q == PRE_LAST) |=> (state_q == ST_BURST && cnt_q == '0));

    // R4: the postamble lasts a single slot
    a_r4_post_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST) |=> (state_q != ST_POST));

    // R6: a start in the last toggle slot chains without a gap
    a_r6_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && cnt_q == last_q && rd_start) |=> (state_q == ST_BURST && cnt_q == '0));

    // R7: a start in the middle of a burst does not restart it
    a_r7_mid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && cnt_q != last_q) |=> (state_q == ST_BURST && cnt_q == $past(cnt_q) + 1'b1));

    // R9: a start in the postamble reopens a preamble
    a_r9_post_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST && rd_start) |=> (state_q == ST_PRE));
endmodule

// File: rtl/rdq_strobe_drv.sv
module rdq_strobe_drv
    import rdq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  rdq_state_e       state,
    input  logic [CNT_W-1:0] slot,
    output logic             dqs,
    output logic             dqs_n,
    output logic             dqs_oe
);
    always_comb begin
        dqs    = 1'b0;
        dqs_n  = 1'b0;
        dqs_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                dqs_oe = 1'b0;
            end
            ST_PRE, ST_POST: begin
                dqs_oe = 1'b1;
                dqs    = 1'b0;
                dqs_n  = 1'b1;
            end
            ST_BURST: begin
                dqs_oe = 1'b1;
                dqs    = ~slot[0];
                dqs_n  = slot[0];
            end
            default: begin
                dqs_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rdq_term.sv
module rdq_term
    import rdq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       odt_on,
    input  rdq_state_e state,
    output logic       dq_term
);
    logic odt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) odt_q <= 1'b0;
        else        odt_q <= odt_on;
    end

    assign dq_term = (state == ST_IDLE) && odt_q;
endmodule

// File: rtl/rd_strobe_framer.sv
module rd_strobe_framer
    import rdq_pkg::*;
#(
    parameter int PRE_SLOTS     = 2,
    parameter int LONG_TOGGLES  = 8,
    parameter int SHORT_TOGGLES = 4
) (
    input  logic clk2x,
    input  logic rst_n,
    input  logic rd_start,
    input  logic burst_chop,
    input  logic odt_on,
    output logic dqs,
    output logic dqs_n,
    output logic dqs_oe,
    output logic dq_term
);
    localparam int CNT_W = $clog2(LONG_TOGGLES + PRE_SLOTS + 1);

    rdq_state_e       state;
    logic [CNT_W-1:0] slot;

    rdq_fsm #(
        .PRE_SLOTS    (PRE_SLOTS),
        .LONG_TOGGLES (LONG_TOGGLES),
        .SHORT_TOGGLES(SHORT_TOGGLES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk2x),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .burst_chop(burst_chop),
        .state     (state),
        .slot      (slot)
    );

    rdq_strobe_drv #(.CNT_W(CNT_W)) u_drv (
        .state (state),
        .slot  (slot),
        .dqs   (dqs),
        .dqs_n (dqs_n),
        .dqs_oe(dqs_oe)
    );

    rdq_term u_term (
        .clk    (clk2x),
        .rst_n  (rst_n),
        .odt_on (odt_on),
        .state  (state),
        .dq_term(dq_term)
    );

    // R5: the pair is complementary whenever it is driven
    a_r5_complement: assert property (@(posedge clk2x) disable iff (!rst_n)
        dqs_oe |-> (dqs_n == ~dqs));

    // R1: a released pair carries no level
    a_r1_quiet_when_off: assert property (@(posedge clk2x) disable iff (!rst_n)
        !dqs_oe |-> (!dqs && !dqs_n));

    // R8: termination is never requested while the strobe is driven
    a_r8_term_excl: assert property (@(posedge clk2x) disable iff (!rst_n)
        dq_term |-> !dqs_oe);

    // R8: while released, termination follows the previous request
    a_r8_term_follow: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!dqs_oe && $past(rst_n)) |-> (dq_term == $past(odt_on)));
endmodule

// File: tb/rd_strobe_framer_test.sv
`timescale 1ns/1ps
module rd_strobe_framer_test;
    logic clk2x = 1'b0;
    logic rst_n = 1'b0;
    logic rd_start = 1'b0;
    logic burst_chop = 1'b0;
    logic odt_on = 1'b0;
    logic dqs, dqs_n, dqs_oe, dq_term;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int    due;
        logic  oe;
        logic  s;
        logic  t;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk2x = ~clk2x;
    always @(posedge clk2x) cyc <= cyc + 1;

    rd_strobe_framer uut (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .burst_chop(burst_chop),
        .odt_on    (odt_on),
        .dqs       (dqs),
        .dqs_n     (dqs_n),
        .dqs_oe    (dqs_oe),
        .dq_term   (dq_term)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: {oe,dqs,dqs_n,term} actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // monitor: compare each expectation in the slot it is due
    initial begin
        forever begin
            @(negedge clk2x);
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                logic en;
                e = sb.pop_front();
                en = e.oe ? ~e.s : 1'b0;
                chk(e.tag, {dqs_oe, dqs, dqs_n, dq_term}, {e.oe, e.s, en, e.t});
            end
        end
    end

    // driver: apply one slot of input and queue the output it should produce
    task automatic step(input logic st, input logic chop, input logic odt,
                        input logic e_oe, input logic e_s, input string tag);
        exp_t e;
        @(posedge clk2x);
        #1;
        rd_start   = st;
        burst_chop = chop;
        odt_on     = odt;
        e.due = cyc + 1;
        e.oe  = e_oe;
        e.s   = e_oe ? e_s : 1'b0;
        e.t   = e_oe ? 1'b0 : odt;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // launch (or chain) a burst; noise injects ignored starts
    task automatic burst(input logic chop, input logic odt, input bit chain, input bit noise);
        int n;
        n = chop ? 4 : 8;
        if (!chain) begin
            step(1'b1, chop, odt, 1'b1, 1'b0, "R2 preamble slot 0");
            step(noise, ~chop, odt, 1'b1, 1'b0, noise ? "R7 start in preamble ignored" : "R2 preamble slot 1");
        end
        for (int i = 0; i < n; i++) begin
            logic st;
            logic ch;
            st = (chain && i == 0) || (noise && i == 2);
            ch = (noise && i == 2) ? ~chop : chop;
            step(st, ch, odt, 1'b1, (i % 2 == 0),
                 (chain && i == 0) ? "R6 chained toggle" :
                 (noise && i == 2) ? "R7 mid-burst start ignored" :
                 (chop ? "R3 short burst toggle" : "R3 long burst toggle"));
        end
    endtask

    task automatic post(input logic odt);
        step(1'b0, 1'b0, odt, 1'b1, 1'b0, "R4 postamble");
    endtask

    task automatic idle(input logic odt, input string tag);
        step(1'b0, 1'b0, odt, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk2x);
        #1;
        chk("R1 in reset", {dqs_oe, dqs, dqs_n, dq_term}, 4'b0000);
        rst_n = 1'b1;
        idle(1'b0, "R1 idle after reset");
        idle(1'b1, "R8 term follows odt high");
        idle(1'b0, "R8 term follows odt low");
        idle(1'b1, "R8 term follows odt high again");

        // long burst, termination requested
        burst(1'b0, 1'b1, 1'b0, 1'b0);
        post(1'b1);
        idle(1'b1, "R4 back to idle, R8 term on");
        idle(1'b0, "R8 term off when odt low");

        // short burst without termination
        burst(1'b1, 1'b0, 1'b0, 1'b0);
        post(1'b0);
        idle(1'b0, "R4 idle after short burst");

        // ignored starts in preamble and mid-burst
        burst(1'b0, 1'b1, 1'b0, 1'b1);
        post(1'b1);
        idle(1'b1, "R7 sequence unchanged, idle");

        // chained bursts: short then long then short
        burst(1'b1, 1'b0, 1'b0, 1'b0);
        burst(1'b0, 1'b0, 1'b1, 1'b0);
        burst(1'b1, 1'b0, 1'b1, 1'b0);
        post(1'b0);

        // start inside postamble reopens preamble
        burst(1'b1, 1'b1, 1'b0, 1'b0);
        post(1'b1);
        burst(1'b0, 1'b1, 1'b0, 1'b0);
        post(1'b1);
        idle(1'b1, "R9 idle after restarted burst");
        idle(1'b0, "R1 idle quiet");

        repeat (4) @(posedge clk2x);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule